// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked sequencer that drives an external asynchronous static RAM of 128K bytes. On the user side it takes one request at a time through a valid/ready handshake that carries an address, write data and a write flag. A read returns its byte through a one-cycle data-valid strobe. On the memory side it drives 17 address lines and two chip selects of opposite polarity (`mem_cs_n` low-true, `mem_cs` high-true). It also drives a low-true output enable and a low-true write strobe, and splits the shared 8-bit data bus into an outgoing value, an incoming value and a drive enable.

Every phase length is a clock-cycle count, found by ceiling division of a nanosecond figure by the clock period. The address moves only while the write strobe is high. A read always ends with a release phase so that the memory has let go of the bus before the controller can drive it again.

The state machine has six states. The named transitions are:
- `S_IDLE` to `S_RD_ACCESS` on an accepted read.
- `S_IDLE` to `S_WR_SETUP` on an accepted write.
- `S_RD_ACCESS` to `S_RD_RELEASE` when the access is done.
- `S_RD_RELEASE` to `S_IDLE` when the release is done.
- `S_WR_SETUP` to `S_WR_STROBE` when the setup is done.
- `S_WR_STROBE` to `S_WR_RECOVER` when the strobe is done.
- `S_WR_RECOVER` to `S_IDLE` when the recovery is done.

Top module: `asram_ctl`

## Requirements
- R1: The memory counts as selected only when `mem_cs_n`=0 and `mem_cs`=1. Whenever the controller is idle, it holds `mem_cs_n`=1, `mem_cs`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_drv`=0.
- R2: An accepted read selects the memory with `mem_oe_n`=0, `mem_we_n`=1 and the bus not driven. This lasts N_RD cycles, where N_RD is the largest of ceil(150/T), ceil(150/T) and ceil(100/T), with T the clock period in ns. N_RD is 38 at T=4.
- R3: `mem_addr` changes only in a cycle where `mem_we_n` is high and was also high in the previous cycle. During a request it equals the accepted address.
- R4: An accepted write runs in three phases:
  - one setup cycle, selected, with `mem_we_n`=1;
  - N_STB cycles with `mem_we_n`=0, where N_STB is the largest of ceil(80/T), ceil(50/T), ceil(150/T)-1 and 1 (37 at T=4);
  - N_REC = max(1, ceil(150/T)-1-N_STB) recovery cycles, selected, with `mem_we_n`=1 (1 at T=4).

  `mem_oe_n` stays 1 throughout.
- R5: Through all write phases `mem_dq_drv`=1 and `mem_dq_out` holds the accepted write byte.
- R6: A read samples `mem_dq_in` in its last access cycle. It shows that byte on `rd_data` with `rd_valid`=1 for exactly one cycle, the first cycle after the access.
- R7: After the access, a read spends N_REL = max(1, ceil(40/T)) cycles (10 at T=4) deselected, with `mem_oe_n`=1 and the bus not driven, before it returns to idle.
- R8: `mem_dq_drv` is never 1 while `mem_oe_n` is 0. When `mem_oe_n` falls, the bus was not driven in the previous cycle.
- R9: `req_ready` is 1 only when idle. It is 0 from the cycle after acceptance for N_RD+N_REL cycles for a read (48 at T=4) and 1+N_STB+N_REC cycles for a write (39 at T=4). A `req_valid` presented while `req_ready` is 0 has no effect on any memory pin.
- R10: During and right after reset, `req_ready`=1, `rd_valid`=0 and the memory pins are in the idle state of R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, low-true |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle strobe for returned read data |
| rd_data | output | 8 | Returned read byte |
| mem_addr | output | 17 | Memory address lines |
| mem_cs_n | output | 1 | Low-true chip select |
| mem_cs | output | 1 | High-true chip select |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_dq_out | output | 8 | Byte driven onto the data bus |
| mem_dq_in | input | 8 | Byte seen on the data bus |
| mem_dq_drv | output | 1 | Controller drives the data bus |

## Verification
The bench runs write-then-read, read-then-write, back-to-back writes with valid held high, and reads of the top and bottom addresses. Each case shows a different fault:
- A controller that skips the release phase would drive the bus while the memory still outputs data, so a write right after a read would collide.
- A controller that lets the address move in the cycle the strobe rises would commit the byte to the wrong location, and the later read would return a stale value.
- An off-by-one in any phase counter moves ready, `rd_valid` or the strobe edge by one cycle, and the per-cycle reference model catches it.

Requests pushed while the controller is busy must leave every pin untouched. A design that latched them would show a changed address or a spurious strobe.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ACCESS,
        S_RD_RELEASE,
        S_WR_SETUP,
        S_WR_STROBE,
        S_WR_RECOVER
    } state_t;

    function automatic int cdiv(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    // a load always restarts the phase: after a nonzero load the timer is busy
    p_load_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0) |=> !expired);

endmodule

// File: rtl/asram_latch.sv
module asram_latch #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take_req,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] wdata_in,
    input  logic          take_rd,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (take_req) begin
            addr_q  <= addr_in;
            wdata_q <= wdata_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= take_rd;
            if (take_rd) begin
                rd_data <= dq_in;
            end
        end
    end

    p_rvalid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(take_rd) |-> $stable(rd_data));

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl #(
    parameter int CLK_NS    = 4,
    parameter int AW        = 17,
    parameter int DW        = 8,
    parameter int RC_NS     = 150,
    parameter int AA_NS     = 150,
    parameter int OE_ACC_NS = 100,
    parameter int OHZ_NS    = 40,
    parameter int WC_NS     = 150,
    parameter int WP_NS     = 80,
    parameter int AWE_NS    = 150,
    parameter int DS_NS     = 50
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rd_valid,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs_n,
    output logic          mem_cs,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    input  logic [DW-1:0] mem_dq_in,
    output logic          mem_dq_drv
);
    import asram_pkg::*;

    localparam int N_RD  = imax(imax(cdiv(RC_NS, CLK_NS), cdiv(AA_NS, CLK_NS)),
                                imax(cdiv(OE_ACC_NS, CLK_NS), 1));
    localparam int N_REL = imax(cdiv(OHZ_NS, CLK_NS), 1);
    localparam int N_STB = imax(imax(cdiv(WP_NS, CLK_NS), cdiv(DS_NS, CLK_NS)),
                                imax(cdiv(AWE_NS, CLK_NS) - 1, 1));
    localparam int N_REC = imax(cdiv(WC_NS, CLK_NS) - 1 - N_STB, 1);
    localparam int N_MAX = imax(imax(N_RD, N_REL), imax(N_STB, N_REC));
    localparam int CW    = $clog2(N_MAX + 1);

    localparam logic [CW-1:0] L_RD  = CW'(N_RD - 1);
    localparam logic [CW-1:0] L_REL = CW'(N_REL - 1);
    localparam logic [CW-1:0] L_SET = '0;
    localparam logic [CW-1:0] L_STB = CW'(N_STB - 1);
    localparam logic [CW-1:0] L_REC = CW'(N_REC - 1);

    state_t        state_q, state_d;
    logic          t_load, t_expired;
    logic [CW-1:0] t_val;
    logic          take_req, take_rd;

    asram_timer #(.W(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    asram_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_req (take_req),
        .addr_in  (req_addr),
        .wdata_in (req_wdata),
        .take_rd  (take_rd),
        .dq_in    (mem_dq_in),
        .addr_q   (mem_addr),
        .wdata_q  (mem_dq_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and phase timer control
    always_comb begin
        state_d  = state_q;
        t_load   = 1'b0;
        t_val    = L_SET;
        take_req = 1'b0;
        take_rd  = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    take_req = 1'b1;
                    t_load   = 1'b1;
                    if (req_write) begin
                        state_d = S_WR_SETUP;
                        t_val   = L_SET;
                    end else begin
                        state_d = S_RD_ACCESS;
                        t_val   = L_RD;
                    end
                end
            end
            S_RD_ACCESS: begin
                if (t_expired) begin
                    take_rd = 1'b1;
                    t_load  = 1'b1;
                    t_val   = L_REL;
                    state_d = S_RD_RELEASE;
                end
            end
            S_RD_RELEASE: begin
                if (t_expired) begin
                    state_d = S_IDLE;
                end
            end
            S_WR_SETUP: begin
                if (t_expired) begin
                    t_load  = 1'b1;
                    t_val   = L_STB;
                    state_d = S_WR_STROBE;
                end
            end
            S_WR_STROBE: begin
                if (t_expired) begin
                    t_load  = 1'b1;
                    t_val   = L_REC;
                    state_d = S_WR_RECOVER;
                end
            end
            S_WR_RECOVER: begin
                if (t_expired) begin
                    state_d = S_IDLE;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // pin decode
    always_comb begin
        req_ready  = 1'b0;
        mem_cs_n   = 1'b1;
        mem_cs     = 1'b0;
        mem_oe_n   = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_drv = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_RD_ACCESS: begin
                mem_cs_n = 1'b0;
                mem_cs   = 1'b1;
                mem_oe_n = 1'b0;
            end
            S_RD_RELEASE: begin
            end
            S_WR_SETUP, S_WR_RECOVER: begin
                mem_cs_n   = 1'b0;
                mem_cs     = 1'b1;
                mem_dq_drv = 1'b1;
            end
            S_WR_STROBE: begin
                mem_cs_n   = 1'b0;
                mem_cs     = 1'b1;
                mem_we_n   = 1'b0;
                mem_dq_drv = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // phase-length counters kept for the checks below
    logic [CW-1:0] we_low_len, oe_low_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_low_len <= '0;
            oe_low_len <= '0;
        end else begin
            we_low_len <= mem_we_n ? '0 : we_low_len + 1'b1;
            oe_low_len <= mem_oe_n ? '0 : oe_low_len + 1'b1;
        end
    end

    p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_drv));

    p_read_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_oe_n) |-> (oe_low_len == CW'(N_RD)));

    p_addr_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n || !$past(mem_we_n)) |-> $stable(mem_addr));

    p_strobe_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (we_low_len == CW'(N_STB)));

    p_strobe_driven_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_drv && $stable(mem_dq_out)));

    p_no_clash_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_drv && !mem_oe_n));

    p_oe_turn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_drv));

    p_busy_after_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/asram_ctl_bench.sv
module asram_ctl_bench;

    localparam int T_NS  = 4;
    // phase counts worked out from the requirements at a 4 ns period
    localparam int RD_ACC = 38;
    localparam int RD_END = RD_ACC + 10;
    localparam int WR_STB_END = 1 + 37;
    localparam int WR_END = WR_STB_END + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [16:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drv;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'hEE;

    int checks = 0;
    int errors = 0;

    always #(T_NS / 2) clk = ~clk;

    asram_ctl u_asram_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rd_valid   (rd_valid),
        .rd_data    (rd_data),
        .mem_addr   (mem_addr),
        .mem_cs_n   (mem_cs_n),
        .mem_cs     (mem_cs),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_drv (mem_dq_drv)
    );

    // behavioural memory
    logic [7:0] mem [int];

    function automatic logic [7:0] mem_get(input logic [16:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return a[7:0] ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model state
    int          op = 0;      // 0 idle, 1 read, 2 write
    int          t = 0;
    logic [16:0] e_addr = '0;
    logic [7:0]  e_wdata = '0;
    bit          pend = 0;
    int          pend_op = 0;
    logic [16:0] pend_addr = '0;
    logic [7:0]  pend_data = '0;
    logic        prev_we = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            // R10: reset state
            chk(req_ready && !rd_valid && mem_cs_n && !mem_cs && mem_oe_n && mem_we_n && !mem_dq_drv,
                "R10 reset pins", {req_ready, rd_valid, mem_cs_n, mem_cs, mem_oe_n, mem_we_n, mem_dq_drv},
                7'b1010110);
            op = 0; pend = 0; prev_we = 1'b1;
        end else begin
            bit   x_rdy, x_sel, x_oe_n, x_we_n, x_drv, x_rv;
            if (pend) begin
                op = pend_op; t = 1; e_addr = pend_addr; e_wdata = pend_data; pend = 0;
            end else if (op != 0) begin
                t++;
                if ((op == 1 && t > RD_END) || (op == 2 && t > WR_END)) op = 0;
            end
            x_rdy = (op == 0); x_sel = 0; x_oe_n = 1; x_we_n = 1; x_drv = 0; x_rv = 0;
            if (op == 1) begin
                if (t <= RD_ACC) begin x_sel = 1; x_oe_n = 0; end
                x_rv = (t == RD_ACC + 1);
            end else if (op == 2) begin
                x_sel = 1; x_drv = 1;
                x_we_n = !(t >= 2 && t <= WR_STB_END);
            end
            chk(req_ready == x_rdy, "R9 ready", req_ready, x_rdy);
            chk(mem_cs_n == !x_sel && mem_cs == x_sel, "R1 chip selects", {mem_cs_n, mem_cs}, {!x_sel, x_sel});
            if (op == 1) begin
                if (t <= RD_ACC) chk(mem_oe_n == x_oe_n && mem_we_n, "R2 read pins", {mem_oe_n, mem_we_n}, 2'b01);
                else chk(mem_oe_n && !mem_dq_drv && mem_cs_n, "R7 release pins", {mem_oe_n, mem_dq_drv, mem_cs_n}, 3'b101);
            end else begin
                chk(mem_oe_n == x_oe_n, "R4 oe during write/idle", mem_oe_n, x_oe_n);
                chk(mem_we_n == x_we_n, "R4 write strobe", mem_we_n, x_we_n);
            end
            chk(mem_dq_drv == x_drv, "R5 bus drive", mem_dq_drv, x_drv);
            chk(!(mem_dq_drv && !mem_oe_n), "R8 bus clash", {mem_dq_drv, mem_oe_n}, 2'b01);
            if (op != 0) chk(mem_addr == e_addr, "R3 address", mem_addr, e_addr);
            if (op == 2) chk(mem_dq_out == e_wdata, "R5 write data", mem_dq_out, e_wdata);
            chk(rd_valid == x_rv, "R6 rd_valid", rd_valid, x_rv);
            if (x_rv) chk(rd_data == mem_get(e_addr), "R6 rd_data", rd_data, mem_get(e_addr));
            // commit a write when the strobe rises
            if (!prev_we && mem_we_n) mem[int'(mem_addr)] = mem_dq_out;
            prev_we = mem_we_n;
            mem_dq_in = (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) ? mem_get(mem_addr) : 8'hEE;
            if (op == 0 && req_valid) begin
                pend = 1; pend_op = req_write ? 2 : 1;
                pend_addr = req_addr; pend_data = req_wdata;
            end
        end
    end

    task automatic issue(input bit w, input logic [16:0] a, input logic [7:0] d);
        bit r;
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        do begin
            @(negedge clk); r = req_ready;
            @(posedge clk);
        end while (!r);
        #1 req_valid = 1'b0;
    endtask

    // R9: valid while busy must be ignored
    task automatic poke_busy(input int n);
        @(posedge clk); #1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h0ABCD; req_wdata = 8'h77;
        repeat (n) @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!req_ready);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(posedge clk);
                #1 rst_n = 1'b1;
                repeat (3) @(negedge clk);
                issue(1'b1, 17'h00010, 8'h3C); wait_idle();
                issue(1'b0, 17'h00010, 8'h00); wait_idle();
                issue(1'b0, 17'h1FFFF, 8'h00); wait_idle();
                // back-to-back writes with valid held across idle
                issue(1'b1, 17'h1FFFF, 8'hFF);
                issue(1'b1, 17'h00000, 8'h00); wait_idle();
                issue(1'b0, 17'h1FFFF, 8'h00);
                issue(1'b0, 17'h00000, 8'h00);
                // write directly behind a read exercises turnaround
                issue(1'b1, 17'h12345, 8'hA5);
                issue(1'b0, 17'h12345, 8'h00);
                poke_busy(5); wait_idle();
                issue(1'b0, 17'h0ABCD, 8'h00); wait_idle();
                issue(1'b1, 17'h00010, 8'hC3);
                poke_busy(3); wait_idle();
                issue(1'b0, 17'h00010, 8'h00); wait_idle();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule